// File: doc/BRIEF.md
# Fractional System Clock Divider

This block turns one fast master clock into a set of slower timing signals for the rest of a chip. A single free-running binary counter supplies four plain divided phases at one half, one quarter, one eighth and one sixteenth of the master rate. Two more outputs run at non-integer ratios. One averages the master rate divided by 4.25 and the other the master rate divided by 2.125. Each is a plain divide-by-4 or divide-by-2 square wave whose phase counter is frozen for one master cycle after every sixteen advancing cycles. That frozen cycle lengthens one period in seventeen master cycles.

The block also takes a DMA request that comes from a separate disk clock domain. It passes that request through a synchronizer chain before any master-domain logic sees it. All outputs come straight from flip-flops. Downstream logic can use them as clock-enable levels or edge sources without combinational glitches. The interface is made of level signals only. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `clk_fracdiv`

## Requirements
- R1: `div_o` equals a 4-bit up counter, cleared at reset, that advances by one on every master edge. Bit k toggles with period 2^(k+1) master cycles: bit 0 is the /2 phase and bit 3 is the /16 phase.
- R2: The divided phases are locked together. `div_o[k]` for k ≥ 1 changes only on an edge where `div_o[k-1]` falls from 1 to 0. So the /4 phase changes only as the /2 phase goes low.
- R3: `frac4_o` is bit 1 of a 2-bit phase counter. The counter advances on every master edge except the stretch edges.
- R4: `frac2_o` is a 1-bit phase that toggles on every master edge except the stretch edges.
- R5: Counting master edges after reset release as 1, 2, 3 and so on, the stretch edges are the multiples of 17. On a stretch edge neither fractional output changes. The first stretch edge therefore comes after exactly 16 advancing cycles.
- R6: While `rst_n` is low, every output is 0.
- R7: A level on `dma_req_i` that is stable before a master edge appears on `dma_req_o` after the second master edge, and not after the first. This holds for both rising and falling requests.
- R8: Outputs change only at master clock edges. They hold constant between one edge and the next.
- R9: Over the first 272 master edges after reset, the rising-edge counts are 136, 68, 34 and 17 for `div_o[0]` to `div_o[3]`. They are 64 for `frac4_o` and 128 for `frac2_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_req_i | input | 1 | DMA request from the disk clock domain, asynchronous to `clk` |
| div_o | output | 4 | Binary divided phases; bit k is master / 2^(k+1) |
| frac4_o | output | 1 | Fractional phase averaging master / 4.25 |
| frac2_o | output | 1 | Fractional phase averaging master / 2.125 |
| dma_req_o | output | 1 | DMA request synchronized to `clk` |

## Verification
The dividers run from reset through a full 272-cycle window. Every cycle is compared against an independent model built from the edge count. This separates a stretch placed at the wrong interval, a stretch that is missing, or an off-by-one start, since any of these shifts every later fractional sample. Total edge counts over the window catch average-rate errors even where individual samples look plausible. The DMA request is raised and then dropped in isolation. This tells a two-stage chain apart from a one-stage or three-stage chain in each direction.

// File: rtl/clk_fracdiv_pkg.sv
package clk_fracdiv_pkg;
  localparam int unsigned DEF_DIV_STAGES  = 4;   // /2 .. /16
  localparam int unsigned DEF_STRETCH_LEN = 17;  // 16 advancing + 1 frozen
  localparam int unsigned DEF_SYNC_STAGES = 2;
  localparam int unsigned DEF_SLOW_W      = 2;   // /4 base -> avg /4.25
  localparam int unsigned DEF_FAST_W      = 1;   // /2 base -> avg /2.125
endpackage

// File: rtl/fd_binary_div.sv
module fd_binary_div #(
  parameter int unsigned STAGES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [STAGES-1:0] div_o
);
  logic [STAGES-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  assign div_o = cnt_q;

  assert_div2_toggle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_q[0] != $past(cnt_q[0])));

  for (genvar k = 1; k < STAGES; k++) begin : g_phase_chk
    assert_div_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q[k] != $past(cnt_q[k])) |-> $fell(cnt_q[k-1]));
  end
endmodule

// File: rtl/fd_stretch_timer.sv
module fd_stretch_timer #(
  parameter int unsigned LEN = 17
) (
  input  logic clk,
  input  logic rst_n,
  output logic hold_o
);
  localparam int unsigned SW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [SW-1:0] LAST = SW'(LEN - 1);

  logic [SW-1:0] slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              slot_q <= '0;
    else if (slot_q == LAST) slot_q <= '0;
    else                     slot_q <= slot_q + 1'b1;
  end

  assign hold_o = (slot_q == LAST);

  // R5: a frozen slot is always followed by an advancing one
  assert_hold_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hold_o |=> !hold_o);
endmodule

// File: rtl/fd_frac_phase.sv
module fd_frac_phase #(
  parameter int unsigned W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  output logic clk_o
);
  logic [W-1:0] ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ph_q <= '0;
    else if (!hold_i) ph_q <= ph_q + 1'b1;
  end

  assign clk_o = ph_q[W-1];

  assert_hold_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> $stable(ph_q));

  // covers R3 (W=2) and R4 (W=1)
  assert_phase_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_i |=> (ph_q != $past(ph_q)));
endmodule

// File: rtl/fd_req_sync.sv
module fd_req_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic req_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], req_i};
  end

  assign req_o = sh_q[STAGES-1];

  assert_sync_chain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sh_q[STAGES-1] == $past(sh_q[STAGES-2])));
endmodule

// File: rtl/clk_fracdiv.sv
module clk_fracdiv
  import clk_fracdiv_pkg::*;
#(
  parameter int unsigned DIV_STAGES  = DEF_DIV_STAGES,
  parameter int unsigned STRETCH_LEN = DEF_STRETCH_LEN,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
  parameter int unsigned SLOW_W      = DEF_SLOW_W,
  parameter int unsigned FAST_W      = DEF_FAST_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  dma_req_i,
  output logic [DIV_STAGES-1:0] div_o,
  output logic                  frac4_o,
  output logic                  frac2_o,
  output logic                  dma_req_o
);
  logic hold;

  fd_binary_div #(.STAGES(DIV_STAGES)) u_bin (
    .clk(clk), .rst_n(rst_n), .div_o(div_o));

  fd_stretch_timer #(.LEN(STRETCH_LEN)) u_tmr (
    .clk(clk), .rst_n(rst_n), .hold_o(hold));

  fd_frac_phase #(.W(SLOW_W)) u_slow (
    .clk(clk), .rst_n(rst_n), .hold_i(hold), .clk_o(frac4_o));

  fd_frac_phase #(.W(FAST_W)) u_fast (
    .clk(clk), .rst_n(rst_n), .hold_i(hold), .clk_o(frac2_o));

  fd_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .req_i(dma_req_i), .req_o(dma_req_o));

  always_comb begin
    assert_reset_quiet_R6: assert (rst_n || (div_o == '0 && !frac4_o && !frac2_o && !dma_req_o));
  end
endmodule

// File: tb/sim_clk_fracdiv.sv
module sim_clk_fracdiv;
  localparam int NCYC = 272;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0;
  logic [3:0] div;
  logic f4, f2, dreq;

  always #2.5 clk = ~clk;

  clk_fracdiv u0 (.clk(clk), .rst_n(rst_n), .dma_req_i(req),
                  .div_o(div), .frac4_o(f4), .frac2_o(f2), .dma_req_o(dreq));

  typedef struct packed { logic [3:0] d; logic a; logic b; } exp_t;
  exp_t exp_q[$];
  int checks = 0, errors = 0;
  bit done = 1'b0, dma_done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // driver: expected output per edge count n, built from R1/R3/R4/R5
  task automatic push_expected(input int n_max);
    for (int n = 0; n <= n_max; n++) begin
      int adv;
      exp_t e;
      adv = n - n / 17;
      e.d = 4'(n);
      e.a = adv[1];
      e.b = adv[0];
      exp_q.push_back(e);
    end
  endtask

  // monitor / scoreboard
  initial begin
    exp_t e;
    logic [3:0] pd, sd;
    logic pa, pb, sa, sb;
    int rise [6];
    push_expected(NCYC);
    foreach (rise[i]) rise[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    e = exp_q.pop_front();
    chk(div == e.d && f4 == 1'b0 && f2 == 1'b0 && dreq == 1'b0, "R6 reset outputs",
        {div, f4, f2, dreq}, 0);
    pd = div; pa = f4; pb = f2;
    rst_n = 1'b1;
    for (int n = 1; n <= NCYC; n++) begin
      @(posedge clk); #1;
      sd = div; sa = f4; sb = f2;
      @(negedge clk);
      chk(sd == div && sa == f4 && sb == f2, "R8 stable between edges",
          {div, f4, f2}, {sd, sa, sb});
      e = exp_q.pop_front();
      chk(div == e.d, "R1 binary phases", div, e.d);
      chk(f4 == e.a, "R3 frac4 phase", f4, e.a);
      chk(f2 == e.b, "R4 frac2 phase", f2, e.b);
      if (div[1] != pd[1])
        chk(pd[0] && !div[0], "R2 /4 moves only as /2 falls", div[0], 0);
      if (n % 17 == 0)
        chk(f4 == pa && f2 == pb, "R5 stretch edge frozen", {f4, f2}, {pa, pb});
      for (int k = 0; k < 4; k++) if (div[k] && !pd[k]) rise[k]++;
      if (f4 && !pa) rise[4]++;
      if (f2 && !pb) rise[5]++;
      pd = div; pa = f4; pb = f2;
    end
    chk(rise[0] == 136, "R9 div2 rises", rise[0], 136);
    chk(rise[1] == 68,  "R9 div4 rises", rise[1], 68);
    chk(rise[2] == 34,  "R9 div8 rises", rise[2], 34);
    chk(rise[3] == 17,  "R9 div16 rises", rise[3], 17);
    chk(rise[4] == 64,  "R9 frac4 rises", rise[4], 64);
    chk(rise[5] == 128, "R9 frac2 rises", rise[5], 128);
    wait (dma_done);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // DMA request stimulus, R7
  initial begin
    wait (rst_n);
    repeat (20) @(negedge clk);
    req = 1'b1;
    @(posedge clk); #1; chk(dreq == 1'b0, "R7 rise not after one edge", dreq, 0);
    @(posedge clk); #1; chk(dreq == 1'b1, "R7 rise after two edges", dreq, 1);
    repeat (3) @(negedge clk);
    req = 1'b0;
    @(posedge clk); #1; chk(dreq == 1'b1, "R7 fall not after one edge", dreq, 1);
    @(posedge clk); #1; chk(dreq == 1'b0, "R7 fall after two edges", dreq, 0);
    dma_done = 1'b1;
  end

  // watchdog
  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 actual %0d expected %0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule